// File: doc/BRIEF.md
# Byte-Wide SFR Port Bank

This block holds the parallel I/O ports of an 8051-class microcontroller behind its special-function-register bus. It contains six ports of eight pins each. Every port has an output latch that the CPU can load as a whole byte or one bit at a time. Most ports also have a per-pin direction register. Four ports have a per-pin open-drain select register. For each pin the block drives a value and an output-enable into a tri-state pad. It also brings the pad input back through a two-stage synchronizer.

A CPU read is combinational on the address. A read marked as part of a read-modify-write instruction returns the output latch. Any other read of a port data address returns the synchronized pin levels. A read of a direction or open-drain address returns that register. An address that no port owns reads as zero and leaves the hit flag low.

The bit-addressable registers are the data latches at 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD8 (ports 0 to 5). Direction registers sit at 0x94, 0x91, 0xB1, 0xC1 and 0xD9 (ports 0, 1, 3, 4, 5). Open-drain selects sit at 0x92, 0xB2, 0xC2 and 0xDA (ports 1, 3, 4, 5). Port k occupies bits [8k+7:8k] of every pin vector.

Top module: `sfr_port_bank`

## Requirements
- R1: After reset every data latch reads 0xFF and every direction and open-drain register reads 0x00.
- R2: A byte write (`sfr_wr`) to a port data address loads that latch; a read-modify-write read (`sfr_rmw`=1) then returns it.
- R3: A bit write (`sfr_bit_wr`) to a port data address sets latch bit `sfr_bit_idx` to `sfr_bit_val` and leaves the other seven bits unchanged. A byte write in the same cycle takes precedence.
- R4: A pin whose direction bit is 0 has its output-enable low, whatever its open-drain bit holds.
- R5: A pin with direction 1 and open-drain 0 is driven: output-enable high, output equal to the latch bit.
- R6: A pin with direction 1 and open-drain 1 drives low only while its latch bit is 0. Its output is 0, and its output-enable is the inverse of the latch bit.
- R7: Port 2 has no direction or open-drain register; its pins are always enabled, in push-pull, carrying the latch. Port 0 has no open-drain register and is always push-pull.
- R8: A non-read-modify-write read of a data address returns pin levels after two clock edges of synchronization. A level that has crossed only one edge still reads as the old value.
- R9: A read of an address that no port owns returns 0x00 with `sfr_hit` low, and a write to such an address changes no state.
- R10: Direction and open-drain registers are written by byte and read back with `sfr_hit` high.
- R11: A bit write to a direction or open-drain address has no effect; only data latches are bit addressable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_idx | input | 3 | Bit index for a bit write |
| sfr_bit_val | input | 1 | Value for a bit write |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Read belongs to a read-modify-write instruction |
| sfr_rdata | output | 8 | Read data |
| sfr_hit | output | 1 | Read address is owned by this block |
| pin_in | input | 48 | Pad input levels, port k at [8k+7:8k] |
| pin_out | output | 48 | Pad output values |
| pin_oe | output | 48 | Pad output enables |

## Verification
The bench builds the bank with its defaults: six ports of eight pins and two synchronizer stages. All three port variants are therefore elaborated together. Port 1 has both direction and open-drain registers, port 0 has direction only, and port 2 has neither. Each variant's pad equations and address ownership can be checked against the others within one run. With two stages, the one-edge-early read and the on-time read of a pin change fall in two adjacent bus cycles.

// File: rtl/sfr_port_pkg.sv
package sfr_port_pkg;
   localparam int PORT_MAX = 6;
   localparam logic [7:0] DATA_ADDR [PORT_MAX] = '{8'h80, 8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hD8};
   localparam logic [7:0] DIR_ADDR  [PORT_MAX] = '{8'h94, 8'h91, 8'h00, 8'hB1, 8'hC1, 8'hD9};
   localparam logic [7:0] OD_ADDR   [PORT_MAX] = '{8'h00, 8'h92, 8'h00, 8'hB2, 8'hC2, 8'hDA};
   // bit k set: port k owns the register
   localparam logic [PORT_MAX-1:0] HAS_DIR = 6'b111011;
   localparam logic [PORT_MAX-1:0] HAS_OD  = 6'b111010;

   typedef enum logic [1:0] {
      PAD_HIZ   = 2'd0,
      PAD_PUSH  = 2'd1,
      PAD_DRAIN = 2'd2
   } pad_mode_e;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("port_sync needs at least two stages");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

   logic [7:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q < 8'd255) age_q <= age_q + 8'd1;
   end

   if (STAGES == 2) begin : g_chk2
      // R8
      sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 8'd2) |-> (q == $past(d, 2)));
   end
endmodule

// File: rtl/port_slice.sv
module port_slice
   import sfr_port_pkg::*;
#(
   parameter int         W       = 8,
   parameter int         IW      = $clog2(W),
   parameter bit         USE_DIR = 1'b1,
   parameter bit         USE_OD  = 1'b1,
   parameter logic [7:0] A_DATA  = 8'h80,
   parameter logic [7:0] A_DIR   = 8'h94,
   parameter logic [7:0] A_OD    = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    addr,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          bit_wr,
   input  logic [IW-1:0] bit_idx,
   input  logic          bit_val,
   input  logic          rmw,
   input  logic [W-1:0]  pins_sync,
   output logic          rd_hit,
   output logic [W-1:0]  rd_data,
   output logic [W-1:0]  pad_out,
   output logic [W-1:0]  pad_oe
);
   logic [W-1:0] latch_q, dir_eff, od_eff;
   logic         data_sel, dir_sel, od_sel;

   assign data_sel = (addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  latch_q <= '1;
      else if (wr && data_sel)     latch_q <= wdata;
      else if (bit_wr && data_sel) latch_q[bit_idx] <= bit_val;
   end

   if (USE_DIR) begin : g_dir
      logic [W-1:0] dir_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    dir_q <= '0;
         else if (wr && addr == A_DIR)  dir_q <= wdata;
      end
      assign dir_sel = (addr == A_DIR);
      assign dir_eff = dir_q;
   end else begin : g_nodir
      assign dir_sel = 1'b0;
      assign dir_eff = '1;
   end

   if (USE_OD) begin : g_od
      logic [W-1:0] od_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   od_q <= '0;
         else if (wr && addr == A_OD)  od_q <= wdata;
      end
      assign od_sel = (addr == A_OD);
      assign od_eff = od_q;
   end else begin : g_nood
      assign od_sel = 1'b0;
      assign od_eff = '0;
   end

   pad_mode_e mode [W];
   always_comb begin
      for (int i = 0; i < W; i++) begin
         if (!dir_eff[i])     mode[i] = PAD_HIZ;
         else if (od_eff[i])  mode[i] = PAD_DRAIN;
         else                 mode[i] = PAD_PUSH;
         case (mode[i])
            PAD_DRAIN: begin pad_oe[i] = ~latch_q[i]; pad_out[i] = 1'b0;       end
            PAD_PUSH:  begin pad_oe[i] = 1'b1;        pad_out[i] = latch_q[i]; end
            default:   begin pad_oe[i] = 1'b0;        pad_out[i] = latch_q[i]; end
         endcase
      end
   end

   assign rd_hit = data_sel | dir_sel | od_sel;

   always_comb begin
      if (data_sel)     rd_data = rmw ? latch_q : pins_sync;
      else if (dir_sel) rd_data = dir_eff;
      else if (od_sel)  rd_data = od_eff;
      else              rd_data = '0;
   end

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_sel && (wr || bit_wr)) |=> $stable(latch_q));

   // R3
   bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !wr && data_sel) |=>
         (((latch_q ^ $past(latch_q)) & ~(W'(1) << $past(bit_idx))) == '0));
endmodule

// File: rtl/sfr_port_bank.sv
module sfr_port_bank
   import sfr_port_pkg::*;
#(
   parameter int NP     = 6,
   parameter int PW     = 8,
   parameter int SYNC_N = 2,
   localparam int IW    = $clog2(PW),
   localparam int TW    = NP * PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    sfr_addr,
   input  logic          sfr_wr,
   input  logic [7:0]    sfr_wdata,
   input  logic          sfr_bit_wr,
   input  logic [IW-1:0] sfr_bit_idx,
   input  logic          sfr_bit_val,
   input  logic          sfr_rd,
   input  logic          sfr_rmw,
   output logic [7:0]    sfr_rdata,
   output logic          sfr_hit,
   input  logic [TW-1:0] pin_in,
   output logic [TW-1:0] pin_out,
   output logic [TW-1:0] pin_oe
);
   if (NP < 1 || NP > PORT_MAX) begin : g_bad_np
      $error("sfr_port_bank: NP out of range");
   end
   if (PW != 8) begin : g_bad_pw
      $error("sfr_port_bank: ports must match the byte-wide bus");
   end

   logic [TW-1:0] pins_sync;
   logic [NP-1:0] hit_v;
   logic [PW-1:0] data_v [NP];

   port_sync #(.W(TW), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync));

   for (genvar p = 0; p < NP; p++) begin : g_port
      port_slice #(
         .W(PW), .IW(IW),
         .USE_DIR(HAS_DIR[p]), .USE_OD(HAS_OD[p]),
         .A_DATA(DATA_ADDR[p]), .A_DIR(DIR_ADDR[p]), .A_OD(OD_ADDR[p])
      ) u_slice (
         .clk(clk), .rst_n(rst_n), .addr(sfr_addr),
         .wr(sfr_wr), .wdata(sfr_wdata),
         .bit_wr(sfr_bit_wr), .bit_idx(sfr_bit_idx), .bit_val(sfr_bit_val),
         .rmw(sfr_rmw), .pins_sync(pins_sync[p*PW +: PW]),
         .rd_hit(hit_v[p]), .rd_data(data_v[p]),
         .pad_out(pin_out[p*PW +: PW]), .pad_oe(pin_oe[p*PW +: PW]));
   end

   always_comb begin
      sfr_rdata = '0;
      for (int p = 0; p < NP; p++) sfr_rdata = sfr_rdata | data_v[p];
      if (!sfr_rd) sfr_rdata = '0;
   end
   assign sfr_hit = sfr_rd & (|hit_v);

   // R9
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rd && !sfr_hit) |-> (sfr_rdata == '0));
endmodule

// File: tb/sfr_port_bank_test.sv
module sfr_port_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = '0;
   logic        sfr_bit_wr = 1'b0;
   logic [2:0]  sfr_bit_idx = '0;
   logic        sfr_bit_val = 1'b0;
   logic        sfr_rd = 1'b0;
   logic        sfr_rmw = 1'b0;
   logic [7:0]  sfr_rdata;
   logic        sfr_hit;
   logic [47:0] pin_in;
   logic [47:0] pin_out;
   logic [47:0] pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sfr_port_bank uut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr), .sfr_bit_idx(sfr_bit_idx),
      .sfr_bit_val(sfr_bit_val), .sfr_rd(sfr_rd), .sfr_rmw(sfr_rmw),
      .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe));

   localparam logic [1:0] K_WR = 2'd0, K_BIT = 2'd1, K_RMW = 2'd2, K_PIN = 2'd3;

   typedef struct packed {
      logic [1:0] kind;
      logic [7:0] addr;
      logic [7:0] data;   // write data, {val,idx} for bit writes, or expected read
      logic       hit;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{K_RMW, 8'h80, 8'hFF, 1'b1, 4'd1},   // R1
      '{K_RMW, 8'hD8, 8'hFF, 1'b1, 4'd1},   // R1
      '{K_PIN, 8'h94, 8'h00, 1'b1, 4'd1},   // R1
      '{K_PIN, 8'hDA, 8'h00, 1'b1, 4'd1},   // R1
      '{K_WR,  8'h90, 8'h5A, 1'b0, 4'd2},
      '{K_RMW, 8'h90, 8'h5A, 1'b1, 4'd2},   // R2
      '{K_PIN, 8'h90, 8'hA1, 1'b1, 4'd8},   // R8
      '{K_BIT, 8'h90, 8'h08, 1'b0, 4'd3},
      '{K_RMW, 8'h90, 8'h5B, 1'b1, 4'd3},   // R3
      '{K_BIT, 8'h90, 8'h06, 1'b0, 4'd3},
      '{K_RMW, 8'h90, 8'h1B, 1'b1, 4'd3},   // R3
      '{K_WR,  8'h91, 8'hF0, 1'b0, 4'd10},
      '{K_PIN, 8'h91, 8'hF0, 1'b1, 4'd10},  // R10
      '{K_BIT, 8'h91, 8'h08, 1'b0, 4'd11},
      '{K_RMW, 8'h91, 8'hF0, 1'b1, 4'd11},  // R11
      '{K_WR,  8'hA1, 8'h33, 1'b0, 4'd9},
      '{K_PIN, 8'hA1, 8'h00, 1'b0, 4'd9},   // R9
      '{K_PIN, 8'h81, 8'h00, 1'b0, 4'd9},   // R9
      '{K_WR,  8'h92, 8'h0C, 1'b0, 4'd10},
      '{K_RMW, 8'h92, 8'h0C, 1'b1, 4'd10}   // R10
   };

   task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic op(input logic [1:0] kind, input logic [7:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output logic hit);
      @(negedge clk);
      sfr_addr = a;
      case (kind)
         K_WR:  begin sfr_wr = 1'b1; sfr_wdata = d; end
         K_BIT: begin sfr_bit_wr = 1'b1; sfr_bit_idx = d[2:0]; sfr_bit_val = d[3]; end
         K_RMW: begin sfr_rd = 1'b1; sfr_rmw = 1'b1; end
         default: sfr_rd = 1'b1;
      endcase
      #1;
      rd = sfr_rdata;
      hit = sfr_hit;
      @(posedge clk);
      #1;
      sfr_wr = 1'b0; sfr_bit_wr = 1'b0; sfr_rd = 1'b0; sfr_rmw = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      logic       hit;
      for (int k = 0; k < 6; k++) pin_in[k*8 +: 8] = 8'hA0 | 8'(k);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 R7: only port 2 drives after reset; every latch is 1
      check("R1 R7 reset oe", pin_oe, 48'h0000_00FF_0000);
      check("R1 reset out", pin_out, {48{1'b1}});

      for (int v = 0; v < NV; v++) begin
         op(VECS[v].kind, VECS[v].addr, VECS[v].data, rd, hit);
         if (VECS[v].kind == K_RMW || VECS[v].kind == K_PIN)
            check($sformatf("R%0d vector %0d", VECS[v].req, v),
                  {39'd0, hit, rd}, {39'd0, VECS[v].hit, VECS[v].data});
      end

      // port 1: latch 1B, dir F0, od 0C
      @(negedge clk);
      check("R4 R5 port1 oe", 48'(pin_oe[15:8]), 48'hF0);
      check("R5 port1 out", 48'(pin_out[15:8]), 48'h1B);
      op(K_WR, 8'h91, 8'hFF, rd, hit);
      @(negedge clk);
      check("R6 port1 oe", 48'(pin_oe[15:8]), 48'hF7);
      check("R6 port1 out", 48'(pin_out[15:8]), 48'h13);
      check("R4 port3 input hiz", 48'(pin_oe[31:24]), 48'h00);

      op(K_WR, 8'hA0, 8'h3C, rd, hit);
      @(negedge clk);
      check("R7 port2 oe", 48'(pin_oe[23:16]), 48'hFF);
      check("R7 port2 out", 48'(pin_out[23:16]), 48'h3C);

      op(K_WR, 8'h94, 8'hFF, rd, hit);
      op(K_WR, 8'h80, 8'h55, rd, hit);
      @(negedge clk);
      check("R7 port0 oe", 48'(pin_oe[7:0]), 48'hFF);
      check("R7 port0 out", 48'(pin_out[7:0]), 48'h55);

      // R8: one edge after the change the read is still old, after two it is new
      @(negedge clk);
      pin_in[31:24] = 8'h5C;
      op(K_PIN, 8'hB0, 8'h00, rd, hit);
      check("R8 one edge", 48'(rd), 48'hA3);
      op(K_PIN, 8'hB0, 8'h00, rd, hit);
      check("R8 two edges", 48'(rd), 48'h5C);
      op(K_RMW, 8'hB0, 8'h00, rd, hit);
      check("R2 rmw latch not pins", 48'(rd), 48'hFF);

      // R9: unmapped write left port 2 untouched
      check("R9 no side effect", 48'(pin_out[23:16]), 48'h3C);

      finish_run();
   end
endmodule